// File: doc/BRIEF.md
# Two-Rate Charge Mode Sequencer

This block sequences a battery charger/discharger. It keeps the operating state and drives three enables that never overlap: a main-current enable, a topping/discharge-current enable, and a bias enable that holds the analog current loop idle while the charger is in reset. It also drives panel indicator copies of the two current enables. An operator press of the reset button returns the charger to reset from any state. Releasing the button starts a run. A run starts in main charge when the two-rate option is chosen. It starts directly in topping/discharge when the active-low single-rate/discharge select is held low.

In two-rate runs, an elapsed-time counter counts whole seconds. One second is a fixed number of base ticks. The block moves from main to topping/discharge, once per run, when the count equals the programmed main duration. A stop request from the timer or from the monitor ends the run and latches a terminated state, which lasts until the next reset press. On every start the current setpoint ramps up from zero: a saturating accumulator adds a fixed step per tick, and its value is clamped to the setpoint of the active mode.

The states are RESET (code 00), MAIN (01), TOPDIS (10) and TERM (11). The transitions are:
- start: RESET to MAIN or to TOPDIS, on release of the button.
- changeover: MAIN to TOPDIS, when the elapsed time is reached.
- stop: MAIN or TOPDIS to TERM, on a stop request.
- abort: any state to RESET, on a debounced press.

Top module: `charge_seq`

## Requirements
- R1: After the asynchronous system reset the state code is 00, bias_en_o is 1, both current enables and both indicators are 0, and setpoint_o is 0.
- R2: At most one of main_en_o, top_en_o and bias_en_o is high at any time. They are high exactly in states 01, 10 and 00 respectively. All three are low in state 11. Each indicator equals its enable.
- R3: On a debounced release of the button while in state 00, the next state is 01 when single_n_i is 1 and 10 when single_n_i is 0.
- R4: In state 01 the block moves to state 10 one clock after the elapsed count equals main_time_i. The count clears in state 00 and advances once per TICKS_PER_SEC ticks, so the move follows exactly main_time_i*TICKS_PER_SEC ticks in state 01. State 10 never returns to 01 without passing through state 00.
- R5: A stop request on stop_tmr_i or stop_mon_i in state 01 or 10 enters state 11. That state drops every enable and forces setpoint_o to 0. It holds after the request is removed, until a button press.
- R6: A debounced button press moves any state to 00 on the next clock. setpoint_o is 0 there, and the ramp restarts from zero on the next start.
- R7: In states 01 and 10, setpoint_o equals min(acc, target). acc starts at 0 and adds RAMP_STEP on each tick, saturating at the all-ones value. target is sp_main_i in state 01 and sp_top_i in state 10.
- R8: The button takes effect only after its synchronized level has differed from the debounced level on DB_TICKS consecutive ticks. A shorter press has no effect on the state.
- R9: Stop requests have no effect while in state 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick_i | input | 1 | Base tick enable, one clock wide |
| btn_i | input | 1 | Reset button, high while pressed, asynchronous |
| single_n_i | input | 1 | Low selects single-rate/discharge start, high selects two-rate |
| main_time_i | input | TW | Programmed main-charge duration in seconds |
| sp_main_i | input | SPW | Programmed main current setpoint |
| sp_top_i | input | SPW | Programmed topping/discharge current setpoint |
| stop_tmr_i | input | 1 | Stop request from the timer, asynchronous |
| stop_mon_i | input | 1 | Stop request from the monitor, asynchronous |
| main_en_o | output | 1 | Main current-source enable |
| top_en_o | output | 1 | Topping/discharge current-source enable |
| bias_en_o | output | 1 | Idle-bias enable, high in reset |
| main_ind_o | output | 1 | Main indicator drive |
| top_ind_o | output | 1 | Topping/discharge indicator drive |
| setpoint_o | output | SPW | Ramped current setpoint |
| state_o | output | 2 | State code: 00 reset, 01 main, 10 topping/discharge, 11 terminated |

## Verification
The assertions assume three things about the inputs. tick_i is a single-cycle pulse. single_n_i, main_time_i and both setpoints stay constant from the release of the button until the next press. The debounced button changes only on a tick. The stimulus sets all configuration inputs while the button is held, before each start. It issues ticks at a fixed spacing of four clocks. It keeps stop requests low across each release, so that the start state depends on single_n_i alone.

// File: rtl/cs_pkg.sv
package cs_pkg;

    typedef enum logic [1:0] {
        ST_RESET  = 2'b00,
        ST_MAIN   = 2'b01,
        ST_TOPDIS = 2'b10,
        ST_TERM   = 2'b11
    } cs_state_t;

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [1:0] ff;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= 2'b00;
                else        ff <= {ff[0], d_i[i]};
            end
            assign q_o[i] = ff[1];
        end
    endgenerate
endmodule

// File: rtl/cs_debounce.sv
module cs_debounce #(
    parameter int DB_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_i,
    output logic db_o
);
    localparam int CW = $clog2(DB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          db_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            db_q  <= 1'b0;
            cnt_q <= '0;
        end else if (raw_i == db_q) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                db_q  <= raw_i;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign db_o = db_q;

    // R8: the debounced level only moves on a tick
    a_r8_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(db_q));
endmodule

// File: rtl/cs_timer.sv
module cs_timer #(
    parameter int TICKS_PER_SEC = 1000,
    parameter int TW            = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          clear_i,
    input  logic          run_i,
    output logic [TW-1:0] elapsed_o
);
    localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(TICKS_PER_SEC - 1);
    localparam logic [TW-1:0] E_MAX  = '1;

    logic [PW-1:0] presc_q;
    logic [TW-1:0] sec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            sec_q   <= '0;
        end else if (clear_i) begin
            presc_q <= '0;
            sec_q   <= '0;
        end else if (run_i && tick_i) begin
            if (presc_q == P_LAST) begin
                presc_q <= '0;
                if (sec_q != E_MAX) sec_q <= sec_q + 1'b1;
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end

    assign elapsed_o = sec_q;

    // R4: the count restarts from zero on each reset
    a_r4_elapsed_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> sec_q == '0);
    // R4: the count never moves backwards while running
    a_r4_elapsed_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> sec_q >= $past(sec_q));
endmodule

// File: rtl/cs_mode_fsm.sv
module cs_mode_fsm
    import cs_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          btn_db_i,
    input  logic          stop_i,
    input  logic          single_n_i,
    input  logic [TW-1:0] main_time_i,
    input  logic [TW-1:0] elapsed_i,
    output cs_state_t     state_o,
    output logic          main_en_o,
    output logic          top_en_o,
    output logic          bias_en_o
);
    cs_state_t st_q, st_d;
    logic      btn_prev_q;
    logic      released;

    assign released = btn_prev_q && !btn_db_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_RESET;
            btn_prev_q <= 1'b0;
        end else begin
            st_q       <= st_d;
            btn_prev_q <= btn_db_i;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RESET: begin
                if (released) st_d = single_n_i ? ST_MAIN : ST_TOPDIS;
            end
            ST_MAIN: begin
                if (btn_db_i)                      st_d = ST_RESET;
                else if (stop_i)                   st_d = ST_TERM;
                else if (elapsed_i == main_time_i) st_d = ST_TOPDIS;
            end
            ST_TOPDIS: begin
                if (btn_db_i)    st_d = ST_RESET;
                else if (stop_i) st_d = ST_TERM;
            end
            ST_TERM: begin
                if (btn_db_i) st_d = ST_RESET;
            end
        endcase
    end

    always_comb begin
        main_en_o = 1'b0;
        top_en_o  = 1'b0;
        bias_en_o = 1'b0;
        unique case (st_q)
            ST_RESET:  bias_en_o = 1'b1;
            ST_MAIN:   main_en_o = 1'b1;
            ST_TOPDIS: top_en_o  = 1'b1;
            ST_TERM:   ;
        endcase
    end

    assign state_o = st_q;

    // R2: no two of the enables are ever high together
    a_r2_exclusive_enables: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_en_o, top_en_o, bias_en_o}));
    // R3: the start state follows the rate select
    a_r3_start_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESET && $fell(btn_db_i)) |=>
            st_q == ($past(single_n_i) ? ST_MAIN : ST_TOPDIS));
    // R4: topping/discharge never falls back to main
    a_r4_no_return: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_TOPDIS |=> st_q != ST_MAIN);
    // R5: the terminated state is held until a press
    a_r5_term_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TERM && !btn_db_i) |=> st_q == ST_TERM);
    // R6: a debounced press always lands in reset
    a_r6_press_resets: assert property (@(posedge clk) disable iff (!rst_n)
        btn_db_i |=> st_q == ST_RESET);
    // R9: stop requests do not move the reset state
    a_r9_reset_ignores_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESET && stop_i && btn_db_i) |=> st_q == ST_RESET);
endmodule

// File: rtl/cs_ramp.sv
module cs_ramp
    import cs_pkg::*;
#(
    parameter int SPW       = 12,
    parameter int RAMP_STEP = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  cs_state_t      state_i,
    input  logic [SPW-1:0] sp_main_i,
    input  logic [SPW-1:0] sp_top_i,
    output logic [SPW-1:0] setpoint_o
);
    localparam logic [SPW:0]   STEP_W = (SPW + 1)'(RAMP_STEP);
    localparam logic [SPW-1:0] ACC_MAX = '1;

    logic [SPW-1:0] acc_q;
    logic [SPW:0]   sum;
    logic [SPW-1:0] target;
    logic           active;

    assign active = (state_i == ST_MAIN) || (state_i == ST_TOPDIS);
    assign sum    = {1'b0, acc_q} + STEP_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (!active) begin
            acc_q <= '0;
        end else if (tick_i) begin
            acc_q <= sum[SPW] ? ACC_MAX : sum[SPW-1:0];
        end
    end

    always_comb begin
        unique case (state_i)
            ST_MAIN:   target = sp_main_i;
            ST_TOPDIS: target = sp_top_i;
            ST_RESET:  target = '0;
            ST_TERM:   target = '0;
        endcase
    end

    assign setpoint_o = (acc_q < target) ? acc_q : target;

    // R6: the accumulator is empty after any cycle spent in reset
    a_r6_ramp_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        state_i == ST_RESET |=> acc_q == '0);
    // R7: with a steady state and target the setpoint only rises
    a_r7_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $stable(state_i) && $stable(target)) |->
            setpoint_o >= $past(setpoint_o));
endmodule

// File: rtl/charge_seq.sv
module charge_seq
    import cs_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int DB_TICKS      = 20,
    parameter int TW            = 16,
    parameter int SPW           = 12,
    parameter int RAMP_STEP     = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           btn_i,
    input  logic           single_n_i,
    input  logic [TW-1:0]  main_time_i,
    input  logic [SPW-1:0] sp_main_i,
    input  logic [SPW-1:0] sp_top_i,
    input  logic           stop_tmr_i,
    input  logic           stop_mon_i,
    output logic           main_en_o,
    output logic           top_en_o,
    output logic           bias_en_o,
    output logic           main_ind_o,
    output logic           top_ind_o,
    output logic [SPW-1:0] setpoint_o,
    output logic [1:0]     state_o
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] async_in, synced;
    logic             btn_db, stop_req;
    logic [TW-1:0]    elapsed;
    cs_state_t        st;

    assign async_in = {stop_mon_i, stop_tmr_i, btn_i};
    assign stop_req = synced[1] | synced[2];

    cs_sync #(.W(NSYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(async_in), .q_o(synced)
    );

    cs_debounce #(.DB_TICKS(DB_TICKS)) u_db (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .raw_i(synced[0]), .db_o(btn_db)
    );

    cs_timer #(.TICKS_PER_SEC(TICKS_PER_SEC), .TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .clear_i(st == ST_RESET),
        .run_i(st == ST_MAIN || st == ST_TOPDIS),
        .elapsed_o(elapsed)
    );

    cs_mode_fsm #(.TW(TW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .btn_db_i(btn_db), .stop_i(stop_req),
        .single_n_i(single_n_i), .main_time_i(main_time_i), .elapsed_i(elapsed),
        .state_o(st), .main_en_o(main_en_o), .top_en_o(top_en_o), .bias_en_o(bias_en_o)
    );

    cs_ramp #(.SPW(SPW), .RAMP_STEP(RAMP_STEP)) u_ramp (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .state_i(st),
        .sp_main_i(sp_main_i), .sp_top_i(sp_top_i), .setpoint_o(setpoint_o)
    );

    assign main_ind_o = main_en_o;
    assign top_ind_o  = top_en_o;
    assign state_o    = st;

    // R5: terminated state carries no current enable and a zero setpoint
    a_r5_term_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TERM) |-> (!main_en_o && !top_en_o && !bias_en_o && setpoint_o == '0));
endmodule

// File: tb/charge_seq_bench.sv
module charge_seq_bench;
    localparam int TPS  = 4;
    localparam int DBT  = 3;
    localparam int TW   = 4;
    localparam int SPW  = 8;
    localparam int STEP = 20;
    localparam int TICK_GAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic btn = 1'b0;
    logic single_n = 1'b1;
    logic [TW-1:0] main_time = '0;
    logic [SPW-1:0] sp_main = '0, sp_top = '0;
    logic stop_tmr = 1'b0, stop_mon = 1'b0;
    logic main_en, top_en, bias_en, main_ind, top_ind;
    logic [SPW-1:0] setpoint;
    logic [1:0] state;

    int checks = 0;
    int errors = 0;
    int acc = 0;
    int main_ticks = 0;
    logic [1:0] prev_state = 2'b00;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    charge_seq #(.TICKS_PER_SEC(TPS), .DB_TICKS(DBT), .TW(TW), .SPW(SPW),
                 .RAMP_STEP(STEP)) u_charge_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .btn_i(btn), .single_n_i(single_n),
        .main_time_i(main_time), .sp_main_i(sp_main), .sp_top_i(sp_top),
        .stop_tmr_i(stop_tmr), .stop_mon_i(stop_mon),
        .main_en_o(main_en), .top_en_o(top_en), .bias_en_o(bias_en),
        .main_ind_o(main_ind), .top_ind_o(top_ind), .setpoint_o(setpoint), .state_o(state)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        int tcnt = 0;
        forever begin
            @(posedge clk);
            #2;
            tcnt++;
            tick = (tcnt % TICK_GAP == 0);
        end
    end

    // continuous model of enables, ramp, start state and main duration
    always @(negedge clk) begin
        if (mon_on) begin
            int tgt, exp_sp;
            check(main_en == (state == 2'b01) && top_en == (state == 2'b10) &&
                  bias_en == (state == 2'b00) && main_ind == main_en && top_ind == top_en,
                  "R2 enables/state", {main_en, top_en, bias_en}, int'(state));
            tgt = (state == 2'b01) ? int'(sp_main) : (state == 2'b10) ? int'(sp_top) : 0;
            exp_sp = (acc < tgt) ? acc : tgt;
            check(int'(setpoint) == exp_sp, "R7 setpoint", int'(setpoint), exp_sp);
            if (prev_state == 2'b00 && state != 2'b00)
                check(state == (single_n ? 2'b01 : 2'b10), "R3 start state",
                      int'(state), single_n ? 1 : 2);
            if (prev_state == 2'b01 && state == 2'b10) begin
                if (main_time == 0)
                    check(main_ticks <= 1, "R4 zero main time", main_ticks, 0);
                else
                    check(main_ticks == int'(main_time) * TPS, "R4 main duration",
                          main_ticks, int'(main_time) * TPS);
            end
            if (prev_state == 2'b10)
                check(state != 2'b01, "R4 no return to main", int'(state), 2);
            if (state == 2'b01 || state == 2'b10) begin
                if (tick) acc = (acc + STEP > 255) ? 255 : acc + STEP;
            end else begin
                acc = 0;
            end
            if (state == 2'b00) main_ticks = 0;
            else if (state == 2'b01 && tick) main_ticks++;
            prev_state = state;
        end
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_btn(input logic v);
        @(posedge clk);
        #2;
        btn = v;
    endtask

    task automatic do_press();
        drive_btn(1'b1);
        wait_neg(30);
        check(state == 2'b00, "R6 press to reset", int'(state), 0);
        check(setpoint == '0 && bias_en, "R6 reset setpoint", int'(setpoint), 0);
    endtask

    task automatic do_run(input int m, input bit sn, input bit spi, input bit use_mon);
        do_press();
        main_time = TW'(m);
        single_n  = sn;
        sp_main   = spi ? 8'd255 : 8'd100;
        sp_top    = spi ? 8'd60  : 8'd200;
        // R9: stop requests while held in reset
        @(posedge clk); #2;
        stop_tmr = 1'b1; stop_mon = 1'b1;
        wait_neg(12);
        check(state == 2'b00, "R9 stop in reset", int'(state), 0);
        @(posedge clk); #2;
        stop_tmr = 1'b0; stop_mon = 1'b0;
        wait_neg(6);
        drive_btn(1'b0);
        for (int i = 0; i < 60 && state == 2'b00; i++) wait_neg(1);
        check(state != 2'b00, "R3 left reset", int'(state), sn ? 1 : 2);
        for (int i = 0; i < 200 && state == 2'b01; i++) wait_neg(1);
        check(state == 2'b10, "R4 reached topping", int'(state), 2);
        wait_neg(40);
        check(state == 2'b10, "R4 stays topping", int'(state), 2);
        // R8: a press lasting one tick is filtered
        drive_btn(1'b1);
        repeat (4) @(posedge clk);
        #2;
        btn = 1'b0;
        wait_neg(30);
        check(state == 2'b10, "R8 short press ignored", int'(state), 2);
        // R5: stop from the timer or the monitor
        @(posedge clk); #2;
        if (use_mon) stop_mon = 1'b1; else stop_tmr = 1'b1;
        wait_neg(6);
        check(state == 2'b11, "R5 stop to terminated", int'(state), 3);
        check(!main_en && !top_en && !bias_en && setpoint == '0, "R5 terminated quiet",
              int'(setpoint), 0);
        @(posedge clk); #2;
        stop_mon = 1'b0; stop_tmr = 1'b0;
        wait_neg(20);
        check(state == 2'b11, "R5 terminated sticky", int'(state), 3);
    endtask

    initial begin
        wait_neg(3);
        check(state == 2'b00 && bias_en && !main_en && !top_en && !main_ind && !top_ind,
              "R1 reset outputs", int'(state), 0);
        check(setpoint == '0, "R1 reset setpoint", int'(setpoint), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        mon_on = 1'b1;
        for (int m = 0; m < 6; m++)
            for (int sn = 0; sn < 2; sn++)
                for (int spi = 0; spi < 2; spi++)
                    do_run(m, sn[0], spi[0], ((m + sn + spi) % 2) == 1);
        // R6: press in the middle of a main-charge ramp
        do_press();
        main_time = 4'd5; single_n = 1'b1; sp_main = 8'd255; sp_top = 8'd60;
        drive_btn(1'b0);
        for (int i = 0; i < 60 && state == 2'b00; i++) wait_neg(1);
        wait_neg(20);
        check(state == 2'b01 && setpoint != '0, "R6 ramp running", int'(setpoint), 1);
        do_press();
        drive_btn(1'b0);
        for (int i = 0; i < 60 && state == 2'b00; i++) wait_neg(1);
        check(state == 2'b01 && setpoint <= 8'(STEP), "R6 fresh soft start",
              int'(setpoint), 0);
        wait_neg(10);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (R1..R9 run): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule